// File: doc/BRIEF.md
# Fluorescent display scan controller

This block scans a multiplexed vacuum-fluorescent display through a bank of 56 output pins. A digit counter steps through the programmed number of digit slots, and each slot lasts a programmed number of clock cycles. At every slot boundary the block fetches one 56-bit word from an external synchronous display RAM, addressed by the slot number, and refreshes the pins from it.

Each pin has its own role. A pin can carry display data taken from the fetched RAM word, or a strobe that the block generates for one digit slot, or the value software wrote into a port latch. The first 16 pins may act as strobes. That lets a display take its digit lines either from RAM patterns or from the built-in strobe generator. The remaining pins act as plain outputs. Software configures the block through a single register write port. The mode bits it writes reach the pins only at the next slot boundary, so a write never glitches a display line in the middle of a slot.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: After reset all configuration registers are zero, `pins` is all zero and `ram_re` is low.
- R2: Writing 0 to bit 0 of register address 0 (enable) stops the scan. In the first cycle after that write, `pins` equals the port latch (address 5), `ram_re` stays low, and the digit and slot counters return to 0.
- R3: A pin whose bit in the role register (address 1) is 0 always drives its port latch bit, also while the scan runs.
- R4: A display pin (role bit 1) whose strobe bit is 0 drives bit i of the RAM word fetched for the current slot, for every slot.
- R5: A pin i below 16 with role bit 1 and strobe bit 1 (strobe register at address 2, bit i) is high only during the slot whose number equals the count of strobe bits set below i. It is low in every other slot, whatever the RAM holds.
- R6: Only bits 15:0 of the strobe register exist. Pins 16 to 55 always use RAM data when they are display pins.
- R7: The digit count register (address 3, bits 3:0) holds N-1. The slots run 0,1,..,N-1 and then wrap to 0. A fetch from a slot at or beyond N-1 goes to slot 0, and every fetch address is at most N-1.
- R8: The slot length register (address 4, bits 7:0) holds L-1, and each slot lasts L cycles. Between two refreshes the pins change only when the port latch or the enable changes.
- R9: A fetch drives `ram_re` high with `ram_raddr` equal to the next slot number, in the last cycle of the current slot. A fetch also happens in the first cycle after enable, with address 0. The RAM returns data one cycle after the fetch, and the pins show the new slot one cycle after that.
- R10: Writes to the role or strobe registers leave the display pins unchanged until the next refresh. The refresh then uses the values as written at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 enable, 1 role, 2 strobe, 3 digit count, 4 slot length, 5 port latch |
| wr_data | input | 56 | Register write data |
| ram_re | output | 1 | Display RAM read enable |
| ram_raddr | output | 4 | Display RAM word address (slot number) |
| ram_rdata | input | 56 | Display RAM data, valid one cycle after `ram_re` |
| pins | output | 56 | Display pin outputs |

## Verification
The bench runs with one-cycle slots, where a fetch happens in every cycle. A design that fetched one cycle late, or that refreshed the pins in the same cycle as the RAM data arrived, would shift every pin by one slot there. It shrinks the digit count while the counter sits above the new limit. A counter that tested for equality instead of crossing the limit would then run off through all 16 addresses. It sets strobe bits above bit 15 and sparse strobe patterns, which catch a rank count that is off by one or that leaks strobes onto high pins. It rewrites the role register in the middle of a long slot and clears the enable in the middle of a scan. These steps expose pins that react before the boundary, and pins that keep showing stale display data after the scan stops.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_ROLE  = 3'd1,
    REG_STRB  = 3'd2,
    REG_DIGN  = 3'd3,
    REG_SLOT  = 3'd4,
    REG_LATCH = 3'd5
  } vfd_reg_e;
endpackage

// File: rtl/vfd_rst_sync.sv
module vfd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/vfd_cfg_regs.sv
module vfd_cfg_regs
  import vfd_pkg::*;
#(
  parameter int NPIN  = 56,
  parameter int NSTRB = 16,
  parameter int DIGW  = 4,
  parameter int SLOTW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [NPIN-1:0]  wr_data,
  output logic             en,
  output logic [NPIN-1:0]  role,
  output logic [NSTRB-1:0] strb,
  output logic [DIGW-1:0]  dig_m1,
  output logic [SLOTW-1:0] len_m1,
  output logic [NPIN-1:0]  latch
);
  logic             en_d;
  logic [NPIN-1:0]  role_d, latch_d;
  logic [NSTRB-1:0] strb_d;
  logic [DIGW-1:0]  dig_m1_d;
  logic [SLOTW-1:0] len_m1_d;

  always_comb begin
    en_d     = en;
    role_d   = role;
    strb_d   = strb;
    dig_m1_d = dig_m1;
    len_m1_d = len_m1;
    latch_d  = latch;
    if (wr_en) begin
      case (vfd_reg_e'(wr_addr))
        REG_CTRL:  en_d     = wr_data[0];
        REG_ROLE:  role_d   = wr_data;
        REG_STRB:  strb_d   = wr_data[NSTRB-1:0];
        REG_DIGN:  dig_m1_d = wr_data[DIGW-1:0];
        REG_SLOT:  len_m1_d = wr_data[SLOTW-1:0];
        REG_LATCH: latch_d  = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      role   <= '0;
      strb   <= '0;
      dig_m1 <= '0;
      len_m1 <= '0;
      latch  <= '0;
    end else if (wr_en) begin
      en     <= en_d;
      role   <= role_d;
      strb   <= strb_d;
      dig_m1 <= dig_m1_d;
      len_m1 <= len_m1_d;
      latch  <= latch_d;
    end
  end
endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer #(
  parameter int DIGW  = 4,
  parameter int SLOTW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIGW-1:0]  dig_m1,
  input  logic [SLOTW-1:0] len_m1,
  output logic             fetch,
  output logic [DIGW-1:0]  fetch_addr,
  output logic [DIGW-1:0]  dig,
  output logic             load
);
  logic [SLOTW-1:0] slot_q, slot_d;
  logic [DIGW-1:0]  dig_q, dig_d, dig_adv;
  logic             run_q, run_d, load_q, load_d;

  always_comb begin
    dig_adv    = (dig_q >= dig_m1) ? '0 : dig_q + 1'b1;
    fetch      = en & (~run_q | (slot_q >= len_m1));
    fetch_addr = run_q ? dig_adv : '0;
    if (!en) begin
      slot_d = '0;
      dig_d  = '0;
      run_d  = 1'b0;
      load_d = 1'b0;
    end else if (fetch) begin
      slot_d = '0;
      dig_d  = fetch_addr;
      run_d  = 1'b1;
      load_d = 1'b1;
    end else begin
      slot_d = slot_q + 1'b1;
      dig_d  = dig_q;
      run_d  = run_q;
      load_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      dig_q  <= '0;
      run_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      dig_q  <= dig_d;
      run_q  <= run_d;
      load_q <= load_d;
    end
  end

  assign dig  = dig_q;
  assign load = load_q;
endmodule

// File: rtl/vfd_pin_mux.sv
module vfd_pin_mux #(
  parameter int NPIN  = 56,
  parameter int NSTRB = 16,
  parameter int DIGW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [DIGW-1:0]  dig,
  input  logic [NPIN-1:0]  ram_rdata,
  input  logic [NPIN-1:0]  role,
  input  logic [NSTRB-1:0] strb,
  input  logic [NPIN-1:0]  latch,
  output logic [NPIN-1:0]  pins,
  output logic [NPIN-1:0]  role_act,
  output logic [NSTRB-1:0] strb_act,
  output logic             disp_on
);
  logic [NSTRB-1:0] hit;
  logic [NPIN-1:0]  fresh, disp_q, disp_d, role_q, role_d;
  logic [NSTRB-1:0] strb_q, strb_d;
  logic             on_q, on_d, take;

  // strobe rank: pin i owns the slot equal to the number of strobe pins below it
  always_comb begin
    logic [DIGW:0] rank;
    rank = '0;
    hit  = '0;
    for (int i = 0; i < NSTRB; i++) begin
      hit[i] = strb[i] & (rank == {1'b0, dig});
      rank   = rank + {{DIGW{1'b0}}, strb[i]};
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_src
    if (g < NSTRB) begin : g_strobe_capable
      assign fresh[g] = strb[g] ? hit[g] : ram_rdata[g];
    end else begin : g_ram_only
      assign fresh[g] = ram_rdata[g];
    end
  end

  assign take = en & load;

  always_comb begin
    disp_d = take ? fresh : disp_q;
    role_d = take ? role  : role_q;
    strb_d = take ? strb  : strb_q;
    on_d   = en & (on_q | load);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
      role_q <= '0;
      strb_q <= '0;
    end else if (take) begin
      disp_q <= disp_d;
      role_q <= role_d;
      strb_q <= strb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_d;
  end

  assign pins     = (en & on_q) ? ((role_q & disp_q) | (~role_q & latch)) : latch;
  assign role_act = role_q;
  assign strb_act = strb_q;
  assign disp_on  = on_q;
endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl #(
  parameter int NPIN  = 56,
  parameter int NSTRB = 16,
  parameter int DIGW  = 4,
  parameter int SLOTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [NPIN-1:0] wr_data,
  output logic            ram_re,
  output logic [DIGW-1:0] ram_raddr,
  input  logic [NPIN-1:0] ram_rdata,
  output logic [NPIN-1:0] pins
);
  localparam int NDIG = 1 << DIGW;

  logic             rst_n_s;
  logic             cfg_en;
  logic [NPIN-1:0]  cfg_role, cfg_latch;
  logic [NSTRB-1:0] cfg_strb;
  logic [DIGW-1:0]  cfg_dig_m1, cur_dig;
  logic [SLOTW-1:0] cfg_len_m1;
  logic             ld;
  logic [NPIN-1:0]  role_act;
  logic [NSTRB-1:0] strb_act;
  logic             disp_on;

  initial begin
    if (NSTRB > NDIG || NSTRB > NPIN)
      $error("vfd_scan_ctrl: strobe-capable pins exceed slots or pins");
  end

  vfd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  vfd_cfg_regs #(.NPIN(NPIN), .NSTRB(NSTRB), .DIGW(DIGW), .SLOTW(SLOTW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en      (cfg_en),
    .role    (cfg_role),
    .strb    (cfg_strb),
    .dig_m1  (cfg_dig_m1),
    .len_m1  (cfg_len_m1),
    .latch   (cfg_latch)
  );

  vfd_scan_timer #(.DIGW(DIGW), .SLOTW(SLOTW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en         (cfg_en),
    .dig_m1     (cfg_dig_m1),
    .len_m1     (cfg_len_m1),
    .fetch      (ram_re),
    .fetch_addr (ram_raddr),
    .dig        (cur_dig),
    .load       (ld)
  );

  vfd_pin_mux #(.NPIN(NPIN), .NSTRB(NSTRB), .DIGW(DIGW)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (cfg_en),
    .load      (ld),
    .dig       (cur_dig),
    .ram_rdata (ram_rdata),
    .role      (cfg_role),
    .strb      (cfg_strb),
    .latch     (cfg_latch),
    .pins      (pins),
    .role_act  (role_act),
    .strb_act  (strb_act),
    .disp_on   (disp_on)
  );
endmodule

// File: rtl/vfd_scan_checker.sv
module vfd_scan_checker #(
  parameter int NPIN  = 56,
  parameter int NSTRB = 16,
  parameter int DIGW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [NPIN-1:0]  latch,
  input logic [NPIN-1:0]  pins,
  input logic             ram_re,
  input logic [DIGW-1:0]  ram_raddr,
  input logic [DIGW-1:0]  dig_m1,
  input logic             ld,
  input logic [NPIN-1:0]  role_act,
  input logic [NSTRB-1:0] strb_act,
  input logic             disp_on
);
  a_r2_idle_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !ram_re);

  a_r2_idle_pins_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pins == latch);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (en && disp_on) |-> $onehot0(pins[NSTRB-1:0] & role_act[NSTRB-1:0] & strb_act));

  a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> ram_raddr <= dig_m1);

  a_r8_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(ld) && $stable(latch)) |-> $stable(pins));
endmodule

bind vfd_scan_ctrl vfd_scan_checker #(.NPIN(NPIN), .NSTRB(NSTRB), .DIGW(DIGW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (cfg_en),
  .latch     (cfg_latch),
  .pins      (pins),
  .ram_re    (ram_re),
  .ram_raddr (ram_raddr),
  .dig_m1    (cfg_dig_m1),
  .ld        (ld),
  .role_act  (role_act),
  .strb_act  (strb_act),
  .disp_on   (disp_on)
);

// File: tb/test_vfd_scan_ctrl.sv
`timescale 1ns/1ps
module test_vfd_scan_ctrl;
  localparam int NP = 56;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [NP-1:0] wr_data = '0;
  logic          ram_re;
  logic [3:0]    ram_raddr;
  logic [NP-1:0] ram_rdata = '0;
  logic [NP-1:0] pins;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  vfd_scan_ctrl i_vfd_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .pins(pins)
  );

  // external display RAM
  logic [NP-1:0] mem [16];
  always @(posedge clk) if (ram_re) ram_rdata <= mem[ram_raddr];

  // behavioural reference model
  bit            m_en, m_run, m_ld, m_on;
  int            m_slot, m_dig, m_dm1, m_len1;
  logic [NP-1:0] m_role, m_latch, m_disp, m_ract;
  logic [15:0]   m_strb;

  function automatic bit strobe_hit(int pin, int d, logic [15:0] s);
    int k = 0;
    for (int j = 0; j < pin; j++) if (s[j]) k++;
    return s[pin] && (k == d);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_run = 0; m_ld = 0; m_on = 0;
      m_slot = 0; m_dig = 0; m_dm1 = 0; m_len1 = 0;
      m_role = '0; m_latch = '0; m_disp = '0; m_ract = '0; m_strb = '0;
    end else begin
      bit iss;
      if (!m_en) m_on = 0;
      else if (m_ld) begin
        for (int i = 0; i < NP; i++)
          m_disp[i] = (i < 16 && m_strb[i]) ? strobe_hit(i, m_dig, m_strb) : mem[m_dig][i];
        m_ract = m_role;
        m_on = 1;
      end
      iss = m_en && (!m_run || m_slot >= m_len1);
      if (!m_en) begin
        m_slot = 0; m_dig = 0; m_run = 0; m_ld = 0;
      end else if (iss) begin
        m_dig = !m_run ? 0 : (m_dig >= m_dm1 ? 0 : m_dig + 1);
        m_slot = 0; m_run = 1; m_ld = 1;
      end else begin
        m_slot++; m_ld = 0;
      end
      if (wr_en) case (wr_addr)
        3'd0: m_en = wr_data[0];
        3'd1: m_role = wr_data;
        3'd2: m_strb = wr_data[15:0];
        3'd3: m_dm1 = int'(wr_data[3:0]);
        3'd4: m_len1 = int'(wr_data[7:0]);
        3'd5: m_latch = wr_data;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [NP-1:0] ep;
      bit er;
      int ea;
      ep = (m_en && m_on) ? ((m_ract & m_disp) | (~m_ract & m_latch)) : m_latch;
      er = m_en && (!m_run || m_slot >= m_len1);
      ea = !m_run ? 0 : (m_dig >= m_dm1 ? 0 : m_dig + 1);
      checks++;
      if (pins !== ep) begin
        errors++;
        $display("FAIL %s pins act=%h exp=%h", phase, pins, ep);
      end
      checks++;
      if (ram_re !== er || (er && int'(ram_raddr) != ea)) begin
        errors++;
        $display("FAIL %s fetch act=%b/%0d exp=%b/%0d", phase, ram_re, ram_raddr, er, ea);
      end
    end
  end

  task automatic wr(input int a, input logic [NP-1:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [NP-1:0] snap;
    for (int d = 0; d < 16; d++)
      mem[d] = {7{8'(d * 37 + 11)}} ^ (56'h1 << (d * 3));
    run(3);
    rst_n = 1'b1;
    run(4);
    // R1: reset state
    check("R1 pins", pins, '0);
    check("R1 ram_re", {55'd0, ram_re}, '0);
    cmp_on = 1;

    // R3: all pins are ports, scan running
    phase = "R3";
    wr(5, 56'h00A5_5A3C_C3F0_0F77);
    wr(0, 1);
    run(30);
    check("R3 port pins", pins, 56'h00A5_5A3C_C3F0_0F77);

    // R4 R7 R8: RAM-driven display pins, 4 slots of 3 cycles
    phase = "R4 R7 R8";
    wr(3, 3);
    wr(4, 2);
    wr(1, {4'h0, {36{1'b1}}, 16'h0});
    run(60);

    // R5 R6 R9: strobes, upper strobe bits ignored, 12 slots of 1 cycle
    phase = "R5 R6 R9";
    wr(2, {NP{1'b1}});
    wr(1, {28'h0, {28{1'b1}}});
    wr(3, 11);
    wr(4, 0);
    run(50);
    wr(4, 3);
    wr(2, 56'h0000_0000_0000_A5C3);
    run(120);

    // R10: role write mid-slot leaves pins alone until the boundary
    phase = "R10";
    wr(4, 20);
    wait (ram_re === 1'b1);
    @(negedge clk);
    while (ram_re !== 1'b1) @(negedge clk);
    run(4);
    snap = pins;
    wr(1, {NP{1'b1}});
    for (int k = 0; k < 5; k++) begin
      check("R10 hold", pins, snap);
      @(negedge clk);
    end
    run(60);

    // R7: shrink digit count while counter is above the new limit
    phase = "R7 wrap";
    wr(4, 1);
    wr(3, 15);
    run(24);
    wr(3, 2);
    run(40);

    // R2: disable mid-scan, pins fall back at once
    phase = "R2";
    wr(0, 0);
    check("R2 pins latch", pins, 56'h00A5_5A3C_C3F0_0F77);
    check("R2 no fetch", {55'd0, ram_re}, '0);
    run(10);
    wr(0, 1);
    run(30);

    cmp_on = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule